// File: doc/BRIEF.md
# Dual-Window Mixed-Width Memory Bridge

This block sits between a 32-bit host port and a local memory built from blocks of two widths: some hold 24-bit cells, others hold 16-bit cells. The host sees that memory through two address windows whose bases arrive as inputs. In the wide window every host word stands for one local cell. In the dense window every host word stands for two neighbouring cells, sixteen bits each. The bridge decodes which window an address hits and turns the host offset into a local cell address. It then runs one or two single-cycle accesses on a synchronous memory port. Each memory access carries a per-bit write mask and a tag that says whether the addressed block is 24 bits wide.

A host access starts with a one-cycle `start` pulse. The direction, address, write data and byte enables stay stable until `ack`. Local cells of a 16-bit block sit in memory bits [15:0]. A 24-bit cell uses all of bits [23:0]. Memory read data appears in the cycle after the cycle in which `mem_en` is high. Blocks are `2**BLK_LAW` cells long, and parameter bit `BLK24[i]` set marks block `i` as 24 bits wide. Only cells below `MEM_WORDS` exist.

Top module: `dual_window_bridge`

## Requirements
- R1: In the wide window on a 24-bit block, host bits [23:0] map to the whole cell. Reads return zero in bits [31:24], and host bits [31:24] are never written.
- R2: In the wide window on a 16-bit block, host bits [23:8] map to the cell. Reads return zero in bits [31:24] and [7:0], and those host bits are never written.
- R3: In the dense window, host word offset w covers cells 2w and 2w+1. Host bits [15:0] go to cell 2w and host bits [31:16] go to cell 2w+1, and the memory accesses cell 2w first.
- R4: A dense access to a 24-bit block transfers cell bits [23:8] only. A write there leaves cell bits [7:0] unchanged.
- R5: In the wide window each byte enable be[k] gates its own byte of the cell. be[3] has no effect.
- R6: A dense half is written only when both of its byte enables are set: be[1:0] for the low half and be[3:2] for the high half.
- R7: `ack` is a one-cycle pulse. Take the edge that samples `start` as edge 0. `ack` is high after edge 1 with one memory cycle for a wide access, after edge 2 with two memory cycles for a dense access, and after edge 0 with no memory cycle for a failed access.
- R8: An access that misses both windows, or that reaches a cell at or above `MEM_WORDS`, reads 32'hFFFFFFFF, causes no memory access, and raises `err` together with `ack` for that one cycle.
- R9: A `start` pulse that arrives while an access is in progress is ignored. It produces no extra `ack` and no extra memory cycle.
- R10: While `mem_en` is high, `mem_w24` equals `BLK24` at the block index of `mem_addr`.
- R11: The wide window spans `4*2**LAW` bytes from `unp_base`, and the dense window spans `2*2**LAW` bytes from `pak_base`. An address just below a base, or at base plus span, misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unp_base | input | AW | Byte base of the wide window |
| pak_base | input | AW | Byte base of the dense window |
| start | input | 1 | One-cycle request pulse |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Host byte address (bits [1:0] ignored) |
| wdata | input | 32 | Host write data |
| be | input | 4 | Host byte enables |
| ack | output | 1 | Access complete, one cycle |
| err | output | 1 | Access failed, high with ack |
| rdata | output | 32 | Read data, valid with ack |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | LAW | Local cell address |
| mem_wdata | output | 24 | Memory write data |
| mem_wmask | output | 24 | Per-bit write mask |
| mem_rdata | input | 24 | Memory read data, one cycle after mem_en |
| mem_w24 | output | 1 | Addressed block is 24 bits wide |

## Verification
The bench goes after the lane placement in both windows. A bridge that put a 16-bit cell on bits [15:0] of the wide word, or swapped the two dense halves, would return shifted or exchanged data on readback through the other window. Dense writes to 24-bit blocks are read back through the wide window. That readback exposes a bridge that clears the low byte, and one that writes a half with only one of its enables set. Window edges and the end of populated memory are probed one word on either side. A decode that is off by one would acknowledge a missing cell, or turn a valid access into an error that still touches memory. A stray `start` pulse in mid-access must not produce a second acknowledge.

// File: rtl/dual_window_bridge.sv
module dual_window_bridge #(
  parameter int AW        = 16,
  parameter int LAW       = 10,
  parameter int BLK_LAW   = 8,
  parameter int MEM_WORDS = 768,
  parameter logic [(1<<(LAW-BLK_LAW))-1:0] BLK24 = 4'b0101
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  unp_base,
  input  logic [AW-1:0]  pak_base,
  input  logic           start,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  input  logic [3:0]     be,
  output logic           ack,
  output logic           err,
  output logic [31:0]    rdata,
  output logic           mem_en,
  output logic           mem_we,
  output logic [LAW-1:0] mem_addr,
  output logic [23:0]    mem_wdata,
  output logic [23:0]    mem_wmask,
  input  logic [23:0]    mem_rdata,
  output logic           mem_w24
);
  localparam int UNP_BYTES = 4 * (2 ** LAW);
  localparam int PAK_BYTES = 2 * (2 ** LAW);
  localparam logic [LAW:0] MEM_LIM = (LAW+1)'(MEM_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_ACC0, S_ACC1, S_FIN} st_t;
  st_t st;
  logic pak_q, err_q;
  logic [LAW-1:0] base_q;
  logic [15:0] lo_q;

  logic [AW-1:0] uoff, poff;
  logic [LAW-1:0] uloc, ploc;
  logic uhit, phit, good;
  assign uoff = addr - unp_base;
  assign poff = addr - pak_base;
  assign uhit = uoff < AW'(UNP_BYTES);
  assign phit = !uhit && (poff < AW'(PAK_BYTES));
  assign uloc = uoff[LAW+1:2];
  assign ploc = {poff[LAW:2], 1'b0};
  assign good = uhit ? ({1'b0, uloc} < MEM_LIM) : (phit && ({1'b0, ploc} < MEM_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pak_q <= 1'b0; err_q <= 1'b0; base_q <= '0; lo_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pak_q  <= !uhit;
          base_q <= uhit ? uloc : ploc;
          err_q  <= !good;
          st     <= good ? S_ACC0 : S_FIN;
        end
        S_ACC0: st <= pak_q ? S_ACC1 : S_FIN;
        S_ACC1: begin lo_q <= half_rd; st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic hsel, hen;
  logic [15:0] hdat, half_rd;
  assign hsel = (st == S_ACC1);
  assign hdat = hsel ? wdata[31:16] : wdata[15:0];
  assign hen  = hsel ? &be[3:2] : &be[1:0];

  assign mem_en   = (st == S_ACC0) || hsel;
  assign mem_we   = mem_en && wr;
  assign mem_addr = {base_q[LAW-1:1], base_q[0] | hsel};
  assign mem_w24  = BLK24[mem_addr[LAW-1:BLK_LAW]];
  assign half_rd  = mem_w24 ? mem_rdata[23:8] : mem_rdata[15:0];

  always_comb begin
    if (pak_q) begin
      mem_wdata = mem_w24 ? {hdat, 8'h00} : {8'h00, hdat};
      mem_wmask = mem_w24 ? {{16{hen}}, 8'h00} : {8'h00, {16{hen}}};
    end else if (mem_w24) begin
      mem_wdata = wdata[23:0];
      mem_wmask = {{8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    end else begin
      mem_wdata = {8'h00, wdata[23:8]};
      mem_wmask = {8'h00, {8{be[2]}}, {8{be[1]}}};
    end
  end

  assign ack   = (st == S_FIN);
  assign err   = ack && err_q;
  assign rdata = err_q ? 32'hFFFF_FFFF :
                 pak_q ? {half_rd, lo_q} :
                 mem_w24 ? {8'h00, mem_rdata} : {8'h00, mem_rdata[15:0], 8'h00};

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  p_err_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n) err |-> ack);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n) err |-> !$past(mem_en));
  p_cell_exists_r8: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> ({1'b0, mem_addr} < MEM_LIM));
  p_pair_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + LAW'(1)) && mem_addr[0]);
  p_narrow_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_w24) |-> (mem_wmask[23:16] == 8'h00));
  p_keep_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_w24 && pak_q) |-> (mem_wmask[7:0] == 8'h00));
endmodule

// File: tb/test_dual_window_bridge.sv
module test_dual_window_bridge;
  localparam logic [15:0] UB = 16'h1000;
  localparam logic [15:0] PB = 16'h4000;
  localparam logic [3:0]  B24 = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic ack, err, mem_en, mem_we, mem_w24;
  logic [31:0] rdata;
  logic [9:0] mem_addr;
  logic [23:0] mem_wdata, mem_wmask, mem_rdata;

  logic [23:0] mem [0:767];
  logic [23:0] shd [0:767];
  int nchk = 0, nerr = 0, mcnt = 0;

  always #5 clk = ~clk;

  dual_window_bridge i_dual_window_bridge (
    .clk(clk), .rst_n(rst_n), .unp_base(UB), .pak_base(PB),
    .start(start), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .ack(ack), .err(err), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
    .mem_w24(mem_w24));

  always @(posedge clk) begin
    if (mem_en) begin
      mcnt <= mcnt + 1;
      mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= (mem[mem_addr] & ~mem_wmask) | (mem_wdata & mem_wmask);
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit is24(input int loc);
    return B24[loc / 256];
  endfunction

  // R10: width tag compared on every clock with a memory access
  always @(negedge clk) if (rst_n && mem_en) chk("R10 tag", {31'b0, mem_w24}, {31'b0, is24(int'(mem_addr))});

  task automatic do_op(input string r, input logic w, input logic [15:0] a, input logic [31:0] d,
                       input logic [3:0] b, input int lat, input logic ee, input logic [31:0] erd,
                       input int emem, input bit poke);
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d; be = b; mcnt = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= lat + 2; i++) begin
      if (i > 0) @(negedge clk);
      if (poke && i == 0) start = 1'b1;
      if (poke && i == 1) start = 1'b0;
      chk({r, " ack"}, {31'b0, ack}, {31'b0, (i == lat)});
      if (i == lat) begin
        chk({r, " err"}, {31'b0, err}, {31'b0, ee});
        if (!w || ee) chk({r, " rdata"}, rdata, erd);
      end
    end
    chk({r, " R7 mem cycles"}, mcnt, emem);
  endtask

  function automatic logic [31:0] urd(input int loc);
    return is24(loc) ? {8'h00, shd[loc]} : {8'h00, shd[loc][15:0], 8'h00};
  endfunction
  function automatic logic [15:0] half(input int loc);
    return is24(loc) ? shd[loc][23:8] : shd[loc][15:0];
  endfunction

  task automatic u_rd(input string r, input int loc);
    do_op(r, 1'b0, UB + 16'(4 * loc), 32'h0, 4'hF, 1, 1'b0, urd(loc), 1, 1'b0);
  endtask
  task automatic u_wr(input string r, input int loc, input logic [31:0] d, input logic [3:0] b);
    do_op(r, 1'b1, UB + 16'(4 * loc), d, b, 1, 1'b0, 32'h0, 1, 1'b0);
    if (is24(loc)) begin
      for (int k = 0; k < 3; k++) if (b[k]) shd[loc][8*k +: 8] = d[8*k +: 8];
    end else begin
      if (b[1]) shd[loc][7:0]  = d[15:8];
      if (b[2]) shd[loc][15:8] = d[23:16];
    end
  endtask
  task automatic p_rd(input string r, input int w, input bit poke);
    do_op(r, 1'b0, PB + 16'(4 * w), 32'h0, 4'hF, 2, 1'b0, {half(2*w+1), half(2*w)}, 2, poke);
  endtask
  task automatic p_wr(input string r, input int w, input logic [31:0] d, input logic [3:0] b);
    do_op(r, 1'b1, PB + 16'(4 * w), d, b, 2, 1'b0, 32'h0, 2, 1'b0);
    for (int h = 0; h < 2; h++) begin
      if (b[2*h +: 2] == 2'b11) begin
        if (is24(2*w+h)) shd[2*w+h][23:8] = d[16*h +: 16];
        else shd[2*w+h][15:0] = d[16*h +: 16];
      end
    end
  endtask
  task automatic bad(input string r, input logic w, input logic [15:0] a);
    do_op(r, w, a, 32'h5A5A5A5A, 4'hF, 0, 1'b1, 32'hFFFF_FFFF, 0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 768; i++) begin
      mem[i] = 24'(i * 24'h1357 + 24'h0A0B0C);
      shd[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset ack", {31'b0, ack}, 32'h0);
    chk("R8 reset err", {31'b0, err}, 32'h0);
    chk("R7 reset mem_en", {31'b0, mem_en}, 32'h0);

    u_rd("R1 wide read 24b", 5);
    u_wr("R1 wide write 24b", 5, 32'hA1B2C3D4, 4'hF);
    u_rd("R1 byte3 dropped", 5);
    u_wr("R5 lanes 0,2", 6, 32'h11223344, 4'b0101);
    u_rd("R5 lanes readback", 6);
    u_wr("R5 lane3 only", 6, 32'hEE000000, 4'b1000);
    u_rd("R5 lane3 no effect", 6);

    u_rd("R2 wide read 16b", 300);
    u_wr("R2 wide write 16b", 300, 32'h55667788, 4'hF);
    u_rd("R2 readback", 300);
    u_wr("R5 16b byte1 only", 300, 32'h00AB0000, 4'b0010);
    u_rd("R5 16b lane readback", 300);
    u_wr("R2 16b lanes 0,3", 301, 32'hFFFFFFFF, 4'b1001);
    u_rd("R2 lanes 0,3 no effect", 301);

    p_rd("R3 dense read 16b", 200, 1'b0);
    p_wr("R3 dense write 16b", 200, 32'hCAFEBEEF, 4'hF);
    u_rd("R3 even cell low half", 400);
    u_rd("R3 odd cell high half", 401);
    p_rd("R3 dense readback", 200, 1'b0);

    p_rd("R4 dense read 24b", 3, 1'b0);
    p_wr("R4 dense write 24b", 3, 32'h1234ABCD, 4'hF);
    u_rd("R4 low byte kept even", 6);
    u_rd("R4 low byte kept odd", 7);
    p_wr("R6 low half only", 3, 32'h99998888, 4'b0111);
    u_rd("R6 low half written", 6);
    u_rd("R6 high half held", 7);
    p_wr("R6 split enables", 3, 32'h77776666, 4'b1001);
    p_rd("R6 nothing written", 3, 1'b0);

    p_rd("R9 stray start", 100, 1'b1);

    bad("R11 miss between windows", 1'b0, 16'h3000);
    bad("R11 below wide base", 1'b0, 16'h0FFC);
    bad("R11 end of wide window", 1'b1, 16'h2000);
    bad("R11 end of dense window", 1'b0, 16'h4800);
    u_rd("R8 last wide cell", 767);
    bad("R8 wide past memory", 1'b1, UB + 16'(4 * 768));
    p_rd("R8 last dense word", 383, 1'b0);
    bad("R8 dense past memory", 1'b1, PB + 16'(4 * 384));
    u_rd("R8 last cell untouched", 767);
    p_rd("R8 no stray write", 3, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule